// File: doc/BRIEF.md
# SMBus Host Command Sequencer with Byte Queues

The block sits between a processor-facing word register port and a bit-level two-wire bus engine. Software fills a 64-entry transmit queue. The first entry is always the address byte, with the read/write flag in bit 0. Software then writes a command word that raises a start/busy flag and carries a protocol code, a packet-error-check enable and a read length. A sequencer then pops the queue and issues byte operations to the engine: start-and-send, send, receive and stop. It ends the transaction by clearing busy and leaving a 3-bit completion code.

Received bytes land in a 64-entry receive queue. Software drains that queue through a data port that reports, per entry, whether the entry holds a data byte or a check byte and whether the check failed. A programmable fill threshold drives a level output, so software can drain the queue in batches. Both queues can be flushed by software in a single cycle.

Register word index (reg_addr): 0 command, 1 queue control, 2 transmit port, 3 receive port. Reads return data one clock after the read strobe.

Top module: `smbh_host_frontend`

## Requirements
- R1: After reset, busy is 0, the command, queue-control and receive-port registers read 0, bus_valid is 0 and rx_thld is 0.
- R2: A write to the command word with bit 31 set while idle starts a transaction. Busy (bit 31) then reads 1. The command word holds the completion code in bits 27:25, the protocol code in bits 12:9, the check enable in bit 8 and the read length in bits 7:0.
- R3: A command write with bit 31 set while busy is ignored. The running transaction continues and the latched protocol and read-length fields stay unchanged.
- R4: A transmit-port write queues bits 7:0; bit 31 tags the byte as the final one. The first queued byte goes out with op 0 (start+send), later bytes with op 1 (send). After the tagged byte is acknowledged, op 3 (stop) is issued and the code is 0.
- R5: If the transmit queue is empty when the next byte is needed and no final byte has been sent, the code is 5. A stop is issued if the address byte already went out; if the queue is empty at start, no bus operation occurs.
- R6: A nack on the address byte gives code 2 and a nack on any later byte gives code 3. Both are followed by a stop.
- R7: Arbitration loss gives code 1 and a timeout gives code 4. Both end the transaction at once, with no stop.
- R8: Protocol code 8 is a block read: after the address, it issues op 2 (receive) as many times as the read length, and bus_last marks the final receive. Any other code runs the write sequence of R4.
- R9: A received byte that finds the receive queue full is discarded. The code becomes 6 and a stop is issued.
- R10: A receive-port read pops one entry and returns bits 31:30 = 00 when empty, 01 for a data byte and 11 for a check byte. Bit 29 flags a check mismatch and bits 7:0 hold the byte.
- R11: In the queue-control word, writing bit 31 flushes the receive queue and bit 30 flushes the transmit queue. Bits 22:16 read the receive fill count and bits 13:8 set the threshold. rx_thld is 1 while the threshold is nonzero and the fill count is at or above it.
- R12: With bit 8 set, a write appends a CRC-8 byte (polynomial 0x07, initial value 0, MSB first) over the address and data bytes. A read fetches one extra byte after the data and compares it with the CRC over the address and the received data.
- R13: bus_valid, bus_op and bus_wdata hold steady from issue until bus_done, and bus_valid is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| rx_thld | output | 1 | Receive fill at or above threshold |
| bus_valid | output | 1 | Byte operation requested |
| bus_op | output | 2 | 0 start+send, 1 send, 2 receive, 3 stop |
| bus_wdata | output | 8 | Byte to send |
| bus_last | output | 1 | Final receive: engine answers with nack |
| bus_done | input | 1 | Engine finished the operation (one-cycle pulse) |
| bus_nack | input | 1 | Sent byte was not acknowledged |
| bus_arb_lost | input | 1 | Arbitration lost during the operation |
| bus_timeout | input | 1 | Engine timed out |
| bus_rdata | input | 8 | Received byte, valid with bus_done |

## Verification
The assertions check the handshake on every cycle: a request stays steady until the engine answers, and no request is raised while idle. They also check that no received byte is pushed into a full queue, that a second start leaves the latched command alone, and that the fill count never exceeds the depth. The completion codes are shown only by the bench scenarios: the order and kind of the emitted byte operations, where the stop falls, and the CRC byte value. The same holds for the receive-port entry format, threshold crossing and flush effects, which the bench observes at the register port.

// File: rtl/smbh_pkg.sv
package smbh_pkg;
  localparam logic [1:0] OP_START = 2'd0;
  localparam logic [1:0] OP_SEND  = 2'd1;
  localparam logic [1:0] OP_RECV  = 2'd2;
  localparam logic [1:0] OP_STOP  = 2'd3;

  localparam logic [2:0] ST_OK       = 3'd0;
  localparam logic [2:0] ST_ARB      = 3'd1;
  localparam logic [2:0] ST_NACK_ADR = 3'd2;
  localparam logic [2:0] ST_NACK_DAT = 3'd3;
  localparam logic [2:0] ST_TMO      = 3'd4;
  localparam logic [2:0] ST_UNDER    = 3'd5;
  localparam logic [2:0] ST_RXFULL   = 3'd6;

  localparam logic [3:0] PROTO_BLK_RD = 4'd8;

  typedef enum logic [1:0] {SQ_IDLE, SQ_NEXT, SQ_WAIT} seq_t;
  typedef enum logic [2:0] {K_ADDR, K_DATA, K_WPEC, K_RDATA, K_RPEC, K_STOP} kind_t;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc, input logic [7:0] b);
    logic [7:0] c;
    logic fb;
    c = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ b[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction
endpackage

// File: rtl/smbh_fifo.sv
module smbh_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         flush,
  input  logic                         push,
  input  logic [WIDTH-1:0]             din,
  input  logic                         pop,
  output logic [WIDTH-1:0]             dout,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rptr];
  assign count   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assert_count_bound_R11: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_flush_empties_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> (cnt == '0));
endmodule

// File: rtl/smbh_seq.sv
module smbh_seq
  import smbh_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_req,
  input  logic [3:0]       cmd_proto,
  input  logic             cmd_pec,
  input  logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic [2:0]       status,
  output logic [3:0]       proto_q,
  output logic             pec_q,
  output logic [LEN_W-1:0] len_q,
  input  logic             tx_empty,
  input  logic [8:0]       tx_head,
  output logic             tx_pop,
  input  logic             rx_full,
  output logic             rx_push,
  output logic [9:0]       rx_din,
  output logic             bus_valid,
  output logic [1:0]       bus_op,
  output logic [7:0]       bus_wdata,
  output logic             bus_last,
  input  logic             bus_done,
  input  logic             bus_nack,
  input  logic             bus_arb_lost,
  input  logic             bus_timeout,
  input  logic [7:0]       bus_rdata
);
  seq_t             st;
  kind_t            kind;
  logic             is_rd, addr_sent, pec_sent, last_tag, stop_pend;
  logic [LEN_W-1:0] remain;
  logic [7:0]       crc;
  logic             need_data;

  // combinational pop: the head is consumed in the cycle it is issued
  assign need_data = (st == SQ_NEXT) && !stop_pend && !tx_empty &&
                     (!addr_sent || (!is_rd && !last_tag));
  assign tx_pop = need_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= SQ_IDLE;
      kind      <= K_ADDR;
      busy      <= 1'b0;
      status    <= ST_OK;
      proto_q   <= '0;
      pec_q     <= 1'b0;
      len_q     <= '0;
      is_rd     <= 1'b0;
      addr_sent <= 1'b0;
      pec_sent  <= 1'b0;
      last_tag  <= 1'b0;
      stop_pend <= 1'b0;
      remain    <= '0;
      crc       <= '0;
      rx_push   <= 1'b0;
      rx_din    <= '0;
      bus_valid <= 1'b0;
      bus_op    <= OP_STOP;
      bus_wdata <= '0;
      bus_last  <= 1'b0;
    end else begin
      rx_push <= 1'b0;
      case (st)
        SQ_IDLE: begin
          if (start_req) begin
            busy      <= 1'b1;
            status    <= ST_OK;
            proto_q   <= cmd_proto;
            pec_q     <= cmd_pec;
            len_q     <= cmd_len;
            is_rd     <= (cmd_proto == PROTO_BLK_RD);
            remain    <= cmd_len;
            crc       <= '0;
            addr_sent <= 1'b0;
            pec_sent  <= 1'b0;
            last_tag  <= 1'b0;
            stop_pend <= 1'b0;
            st        <= SQ_NEXT;
          end
        end
        SQ_NEXT: begin
          st <= SQ_WAIT;
          bus_valid <= 1'b1;
          bus_last  <= 1'b0;
          if (stop_pend) begin
            bus_op <= OP_STOP;
            kind   <= K_STOP;
          end else if (!addr_sent) begin
            if (tx_empty) begin
              status    <= ST_UNDER;
              busy      <= 1'b0;
              bus_valid <= 1'b0;
              st        <= SQ_IDLE;
            end else begin
              bus_op    <= OP_START;
              bus_wdata <= tx_head[7:0];
              last_tag  <= tx_head[8];
              kind      <= K_ADDR;
            end
          end else if (is_rd) begin
            if (remain != '0) begin
              bus_op   <= OP_RECV;
              bus_last <= (remain == LEN_W'(1)) && !pec_q;
              kind     <= K_RDATA;
            end else if (pec_q && !pec_sent) begin
              bus_op   <= OP_RECV;
              bus_last <= 1'b1;
              kind     <= K_RPEC;
            end else begin
              bus_op <= OP_STOP;
              kind   <= K_STOP;
            end
          end else if (last_tag) begin
            if (pec_q && !pec_sent) begin
              bus_op    <= OP_SEND;
              bus_wdata <= crc;
              kind      <= K_WPEC;
            end else begin
              bus_op <= OP_STOP;
              kind   <= K_STOP;
            end
          end else if (tx_empty) begin
            status <= ST_UNDER;
            bus_op <= OP_STOP;
            kind   <= K_STOP;
          end else begin
            bus_op    <= OP_SEND;
            bus_wdata <= tx_head[7:0];
            last_tag  <= tx_head[8];
            kind      <= K_DATA;
          end
        end
        SQ_WAIT: begin
          if (bus_done) begin
            bus_valid <= 1'b0;
            st        <= SQ_NEXT;
            if (kind == K_STOP) begin
              busy <= 1'b0;
              st   <= SQ_IDLE;
            end else if (bus_arb_lost) begin
              status <= ST_ARB;
              busy   <= 1'b0;
              st     <= SQ_IDLE;
            end else if (bus_timeout) begin
              status <= ST_TMO;
              busy   <= 1'b0;
              st     <= SQ_IDLE;
            end else if (kind == K_ADDR || kind == K_DATA || kind == K_WPEC) begin
              if (bus_nack) begin
                status    <= (kind == K_ADDR) ? ST_NACK_ADR : ST_NACK_DAT;
                stop_pend <= 1'b1;
              end else begin
                if (kind != K_WPEC) crc <= crc8_step(crc, bus_wdata);
                if (kind == K_ADDR) addr_sent <= 1'b1;
                if (kind == K_WPEC) pec_sent <= 1'b1;
              end
            end else if (rx_full) begin
              status    <= ST_RXFULL;
              stop_pend <= 1'b1;
            end else begin
              rx_push <= 1'b1;
              if (kind == K_RPEC) begin
                rx_din   <= {1'b1, (bus_rdata != crc), bus_rdata};
                pec_sent <= 1'b1;
              end else begin
                rx_din <= {2'b00, bus_rdata};
                crc    <= crc8_step(crc, bus_rdata);
                remain <= remain - 1'b1;
              end
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assert_hold_request_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_op) && $stable(bus_wdata)));
  assert_idle_quiet_R13: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !bus_valid);
  assert_no_rx_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    rx_push |-> !rx_full);
  assert_ignore_restart_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && start_req) |=> ($stable(proto_q) && $stable(len_q)));
  assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst)
    status != 3'd7);
endmodule

// File: rtl/smbh_host_frontend.sv
module smbh_host_frontend
  import smbh_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int RX_DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        rx_thld,
  output logic        bus_valid,
  output logic [1:0]  bus_op,
  output logic [7:0]  bus_wdata,
  output logic        bus_last,
  input  logic        bus_done,
  input  logic        bus_nack,
  input  logic        bus_arb_lost,
  input  logic        bus_timeout,
  input  logic [7:0]  bus_rdata
);
  localparam int TCW   = $clog2(TX_DEPTH + 1);
  localparam int RCW   = $clog2(RX_DEPTH + 1);
  localparam int LEN_W = 8;

  localparam logic [1:0] A_CMD = 2'd0;
  localparam logic [1:0] A_QCT = 2'd1;
  localparam logic [1:0] A_TXP = 2'd2;
  localparam logic [1:0] A_RXP = 2'd3;

  logic             start_req, tx_push, rx_pop, flush_rx, flush_tx;
  logic             busy;
  logic [2:0]       status;
  logic [3:0]       proto_q;
  logic             pec_q;
  logic [LEN_W-1:0] len_q;
  logic             tx_empty, tx_full, tx_pop;
  logic [8:0]       tx_head;
  logic [TCW-1:0]   tx_count;
  logic             rx_empty, rx_full, rx_push;
  logic [9:0]       rx_din, rx_head;
  logic [RCW-1:0]   rx_count;
  logic [5:0]       thld_q;
  logic             unused_bits;

  assign start_req = reg_wr && (reg_addr == A_CMD) && reg_wdata[31];
  assign tx_push   = reg_wr && (reg_addr == A_TXP);
  assign rx_pop    = reg_rd && (reg_addr == A_RXP);
  assign flush_rx  = reg_wr && (reg_addr == A_QCT) && reg_wdata[31];
  assign flush_tx  = reg_wr && (reg_addr == A_QCT) && reg_wdata[30];
  assign unused_bits = ^{reg_wdata[29:14], tx_full, tx_count};

  smbh_fifo #(.WIDTH(9), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(flush_tx), .push(tx_push),
    .din({reg_wdata[31], reg_wdata[7:0]}), .pop(tx_pop), .dout(tx_head),
    .empty(tx_empty), .full(tx_full), .count(tx_count));

  smbh_fifo #(.WIDTH(10), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(flush_rx), .push(rx_push),
    .din(rx_din), .pop(rx_pop), .dout(rx_head),
    .empty(rx_empty), .full(rx_full), .count(rx_count));

  smbh_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst(rst), .start_req(start_req),
    .cmd_proto(reg_wdata[12:9]), .cmd_pec(reg_wdata[8]), .cmd_len(reg_wdata[7:0]),
    .busy(busy), .status(status), .proto_q(proto_q), .pec_q(pec_q), .len_q(len_q),
    .tx_empty(tx_empty), .tx_head(tx_head), .tx_pop(tx_pop),
    .rx_full(rx_full), .rx_push(rx_push), .rx_din(rx_din),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_last(bus_last),
    .bus_done(bus_done), .bus_nack(bus_nack), .bus_arb_lost(bus_arb_lost),
    .bus_timeout(bus_timeout), .bus_rdata(bus_rdata));

  always_ff @(posedge clk) begin
    if (rst) begin
      thld_q    <= '0;
      reg_rdata <= '0;
      rx_thld   <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == A_QCT) thld_q <= reg_wdata[13:8];
      rx_thld <= (thld_q != '0) && (32'(rx_count) >= 32'(thld_q));
      if (reg_rd) begin
        case (reg_addr)
          A_CMD: reg_rdata <= {busy, 3'b000, status, 12'h000, proto_q, pec_q, len_q};
          A_QCT: reg_rdata <= {9'h000, 7'(rx_count), 2'b00, thld_q, 8'h00};
          A_TXP: reg_rdata <= '0;
          default: reg_rdata <= rx_empty ? 32'h0 :
                     {(rx_head[9] ? 2'b11 : 2'b01), rx_head[8], 21'h0, rx_head[7:0]};
        endcase
      end
    end
  end

  assert_busy_rises_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start_req) |=> busy);
endmodule

// File: tb/test_smbh_host_frontend.sv
`timescale 1ns/1ps
module test_smbh_host_frontend;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic rx_thld, bus_valid, bus_last;
  logic [1:0] bus_op;
  logic [7:0] bus_wdata;
  logic bus_done = 0, bus_nack = 0, bus_arb_lost = 0, bus_timeout = 0;
  logic [7:0] bus_rdata = 0;

  int total = 0, bad = 0;
  int op_n = 0, rd_n = 0, resp_delay = 1;
  int nack_at = -1, arb_at = -1, tmo_at = -1;
  logic [1:0] ops [0:127];
  logic [7:0] sent [0:127];
  logic       lastf [0:127];
  logic [7:0] rdat [0:127];
  bit finished = 0;

  always #2.5 clk = ~clk;

  smbh_host_frontend i_smbh_host_frontend (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rx_thld(rx_thld),
    .bus_valid(bus_valid), .bus_op(bus_op), .bus_wdata(bus_wdata), .bus_last(bus_last),
    .bus_done(bus_done), .bus_nack(bus_nack), .bus_arb_lost(bus_arb_lost),
    .bus_timeout(bus_timeout), .bus_rdata(bus_rdata));

  function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] x = c ^ b;
    for (int k = 0; k < 8; k++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  // bus engine model
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && bus_valid) begin
        int idx;
        idx = op_n;
        ops[idx] = bus_op; sent[idx] = bus_wdata; lastf[idx] = bus_last;
        op_n++;
        repeat (resp_delay) @(negedge clk);
        bus_done = 1;
        bus_nack = (idx == nack_at);
        bus_arb_lost = (idx == arb_at);
        bus_timeout = (idx == tmo_at);
        if (ops[idx] == 2'd2) begin bus_rdata = rdat[rd_n]; rd_n++; end
        @(negedge clk);
        bus_done = 0; bus_nack = 0; bus_arb_lost = 0; bus_timeout = 0;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b, input bit last);
    wr(2'd2, {last, 23'h0, b});
  endtask

  task automatic prep(input logic [5:0] thld);
    wr(2'd1, {2'b11, 16'h0, thld, 8'h0});
    op_n = 0; rd_n = 0; nack_at = -1; arb_at = -1; tmo_at = -1;
  endtask

  task automatic go(input logic [3:0] proto, input bit pec, input logic [7:0] len);
    wr(2'd0, {1'b1, 18'h0, proto, pec, len});
  endtask

  task automatic wait_idle(output logic [2:0] code);
    logic [31:0] v;
    v = 32'h8000_0000;
    for (int n = 0; n < 3000 && v[31]; n++) rd(2'd0, v);
    code = v[27:25];
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 cmd", v, 0);
    rd(2'd1, v); chk("R1 qctl", v, 0);
    rd(2'd3, v); chk("R1 rxport", v, 0);
    chk("R1 bus_valid", bus_valid, 0);
    chk("R1 rx_thld", rx_thld, 0);
  endtask

  task automatic t_write;
    logic [31:0] v; logic [2:0] c;
    prep(0);
    push(8'hA0, 0); push(8'h11, 0); push(8'h22, 0); push(8'h33, 1);
    go(4'd7, 0, 8'h00);
    rd(2'd0, v);
    chk("R2 busy", v[31], 1); chk("R2 proto", v[12:9], 7);
    wait_idle(c);
    chk("R4 code", c, 0); chk("R4 opcount", op_n, 5);
    chk("R4 start op", ops[0], 0); chk("R4 addr", sent[0], 8'hA0);
    chk("R4 data1", {ops[1], sent[1]}, {2'd1, 8'h11});
    chk("R4 data3", {ops[3], sent[3]}, {2'd1, 8'h33});
    chk("R4 stop", ops[4], 3);
  endtask

  task automatic t_nack;
    logic [2:0] c;
    prep(0); nack_at = 0;
    push(8'hA0, 0); push(8'h55, 1); go(4'd7, 0, 0); wait_idle(c);
    chk("R6 addr nack code", c, 2); chk("R6 addr nack ops", op_n, 2); chk("R6 stop", ops[1], 3);
    prep(0); nack_at = 2;
    push(8'hA0, 0); push(8'h01, 0); push(8'h02, 0); push(8'h03, 1);
    go(4'd7, 0, 0); wait_idle(c);
    chk("R6 data nack code", c, 3); chk("R6 data nack ops", op_n, 4); chk("R6 stop2", ops[3], 3);
  endtask

  task automatic t_underrun;
    logic [2:0] c;
    prep(0);
    push(8'hA0, 0); push(8'h01, 0); go(4'd7, 0, 0); wait_idle(c);
    chk("R5 code", c, 5); chk("R5 ops", op_n, 3); chk("R5 stop", ops[2], 3);
    prep(0);
    push(8'hA0, 0); push(8'h01, 1);
    wr(2'd1, 32'h4000_0000);  // flush transmit only
    go(4'd7, 0, 0); wait_idle(c);
    chk("R5 R11 empty start code", c, 5); chk("R5 R11 no bus op", op_n, 0);
  endtask

  task automatic t_arb_tmo;
    logic [2:0] c;
    prep(0); arb_at = 1;
    push(8'hA0, 0); push(8'h01, 0); push(8'h02, 1); go(4'd7, 0, 0); wait_idle(c);
    chk("R7 arb code", c, 1); chk("R7 arb no stop", op_n, 2);
    prep(0); tmo_at = 0;
    push(8'hA0, 0); push(8'h01, 1); go(4'd7, 0, 0); wait_idle(c);
    chk("R7 tmo code", c, 4); chk("R7 tmo no stop", op_n, 1);
  endtask

  task automatic t_read;
    logic [31:0] v; logic [2:0] c;
    prep(6'd3);
    for (int i = 0; i < 4; i++) rdat[i] = 8'h40 + 8'(i);
    push(8'hA1, 0); go(4'd8, 0, 8'd4); wait_idle(c);
    chk("R8 code", c, 0); chk("R8 ops", op_n, 6);
    chk("R8 recv op", ops[1], 2); chk("R8 not last", lastf[3], 0); chk("R8 last", lastf[4], 1);
    chk("R8 stop", ops[5], 3);
    rd(2'd1, v); chk("R11 count", v[22:16], 4); chk("R11 thld field", v[13:8], 3);
    chk("R11 rx_thld high", rx_thld, 1);
    for (int i = 0; i < 4; i++) begin
      rd(2'd3, v); chk("R10 data entry", v, {2'b01, 1'b0, 21'h0, 8'h40 + 8'(i)});
    end
    rd(2'd3, v); chk("R10 empty", v, 0);
    chk("R11 rx_thld low", rx_thld, 0);
    prep(0);
    push(8'hA0, 0); push(8'h09, 1); go(4'd3, 0, 8'd4); wait_idle(c);
    chk("R8 other proto writes", {ops[1], sent[1]}, {2'd1, 8'h09}); chk("R8 other ops", op_n, 3);
  endtask

  task automatic t_rxfull;
    logic [31:0] v; logic [2:0] c;
    prep(0);
    for (int i = 0; i < 70; i++) rdat[i] = 8'(i);
    push(8'hA1, 0); go(4'd8, 0, 8'd70); wait_idle(c);
    chk("R9 code", c, 6); chk("R9 ops", op_n, 67); chk("R9 stop", ops[66], 3);
    rd(2'd1, v); chk("R9 count 64", v[22:16], 64);
    rd(2'd3, v); chk("R9 first kept", v[7:0], 0);
    wr(2'd1, 32'h8000_0000);
    rd(2'd1, v); chk("R11 flushed", v[22:16], 0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v; logic [2:0] c;
    prep(0); resp_delay = 6;
    push(8'hA0, 0); push(8'h05, 1);
    go(4'd7, 0, 8'd0);
    go(4'd8, 0, 8'd9);
    rd(2'd0, v);
    chk("R3 still busy", v[31], 1); chk("R3 proto kept", v[12:9], 7); chk("R3 len kept", v[7:0], 0);
    wait_idle(c);
    chk("R3 code", c, 0); chk("R3 ops", op_n, 3); chk("R3 send op", ops[1], 1);
    resp_delay = 1;
  endtask

  task automatic t_pec;
    logic [31:0] v; logic [2:0] c; logic [7:0] crc;
    prep(0);
    push(8'hA0, 0); push(8'h12, 0); push(8'h34, 1); go(4'd7, 1, 0); wait_idle(c);
    crc = bcrc(bcrc(bcrc(8'h00, 8'hA0), 8'h12), 8'h34);
    chk("R12 wpec code", c, 0); chk("R12 wpec ops", op_n, 5);
    chk("R12 wpec byte", {ops[3], sent[3]}, {2'd1, crc}); chk("R12 wpec stop", ops[4], 3);
    for (int pass = 0; pass < 2; pass++) begin
      prep(0);
      rdat[0] = 8'h5A; rdat[1] = 8'hC3;
      crc = bcrc(bcrc(bcrc(8'h00, 8'hA1), 8'h5A), 8'hC3);
      rdat[2] = (pass == 0) ? crc : (crc ^ 8'h01);
      push(8'hA1, 0); go(4'd8, 1, 8'd2); wait_idle(c);
      chk("R12 rpec ops", op_n, 5);
      chk("R12 data not last", lastf[2], 0); chk("R12 pec last", lastf[3], 1);
      rd(2'd3, v); chk("R10 R12 data", v, {2'b01, 1'b0, 21'h0, 8'h5A});
      rd(2'd3, v);
      rd(2'd3, v);
      chk("R10 R12 pec entry", v, {2'b11, (pass == 1), 21'h0, rdat[2]});
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 0;
    t_reset;
    t_write;
    t_nack;
    t_underrun;
    t_arb_tmo;
    t_read;
    t_rxfull;
    t_busy_ignore;
    t_pec;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule